// File: doc/BRIEF.md
# Daisy-Chainable Serial Command and Fault Port

This block is the serial slave port of an eight-channel output driver. A host selects the device by raising an active-high select line. It then clocks bytes in on the data-in line and reads the data-out line. Data out is tri-stated between frames, which is modelled here as a data bit plus an output enable. At the start of each frame the port takes a copy of the driver's eight fault flags and shifts them out first. After those eight bits, every bit received on data in comes back out on data out eight serial clocks later. Several devices can therefore sit in one chain with a shared serial clock.

When select falls, the last complete byte of the frame is written into the command register, one bit per output. The port then decides whether the frame was well formed. Only a well-formed frame produces a single-cycle request that clears the fault latches. All serial inputs are brought into the system clock domain through synchronizer flops. Every edge is detected there. Select is filtered against short pulses and against re-selection that comes too soon after the previous frame.

Top module: `chain_spi_if`

## Requirements
- R1: `sdOutEn` is 0 outside a frame and `sdOut` is then 0. `sdOutEn` goes to 1 only when a frame is accepted and returns to 0 when select is released.
- R2: The first eight bits on `sdOut` are the `faultIn` value captured when the frame starts, bit 7 (channel 8) first and bit 0 (channel 1) last. Later changes on `faultIn` do not alter these bits.
- R3: From the ninth bit on, `sdOut` presents the `sdIn` bit that was sampled eight serial clocks earlier.
- R4: `sdIn` is sampled on the rising edge of the serial clock. `sdOut` changes only after a falling edge, so it is steady while the serial clock is high.
- R5: At frame end, `cmdOut` takes the last complete byte received, first bit in as bit 7. Bit k drives output k+1, and 1 means on. `cmdOut` does not change within a frame.
- R6: Trailing bits that do not complete a byte are discarded. A frame with no complete byte leaves `cmdOut` unchanged.
- R7: `faultClr` pulses high for exactly one cycle at frame end. It pulses only if three conditions hold: the bit count is a nonzero multiple of 8, the serial clock is low at release, and the serial clock was low at frame start.
- R8: A select pulse shorter than `CS_FILT_CYC` system cycles (after synchronization) is ignored and changes no output.
- R9: After reset or after a frame ends, select must be low for `MIN_LOW_CYC` cycles before a new frame is accepted. A select pulse that rises earlier is ignored for its whole length.
- R10: After reset, `cmdOut` is 0, `faultClr` is 0 and `sdOutEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Select from host, active high, asynchronous |
| sclkIn | input | 1 | Serial clock from host, asynchronous |
| sdIn | input | 1 | Serial data from host |
| faultIn | input | NCH | Latched fault flags, bit k is channel k+1 |
| cmdOut | output | NCH | Command register, bit k turns output k+1 on |
| faultClr | output | 1 | One-cycle request to clear the fault latches |
| sdOut | output | 1 | Serial data toward host or next device |
| sdOutEn | output | 1 | Drive enable for `sdOut` (low means high impedance) |

## Verification
Frame end is the one cycle where two functions coincide. The command register is written and, for a valid frame, the clear request fires in that same cycle. A monitor records `cmdOut` on the cycle `faultClr` is high and compares it with the byte the frame carried. The bench also changes `faultIn` right after a frame starts, so fault capture and serial shifting run at the same time. It then checks that the first byte still shows the earlier flags. Frames that break one validity condition each, by partial byte, clock high at start or clock high at release, must still commit a complete byte while withholding the clear.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
  // strobes from control to datapath, each valid for one system cycle
  typedef struct packed {
    logic load;      // frame accepted: capture fault flags
    logic sample;    // serial clock rose: take data bit
    logic byteDone;  // this sample completes a byte
    logic shift;     // serial clock fell: advance transmit register
    logic commit;    // frame ended with at least one full byte
  } dpStrobe_t;
endpackage

// File: rtl/chain_spi_sync.sv
module chain_spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/chain_spi_ctrl.sv
module chain_spi_ctrl
  import chain_spi_pkg::*;
#(
  parameter int CS_FILT_CYC = 12,
  parameter int MIN_LOW_CYC = 200,
  parameter int BYTE_BITS   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      sclkS,
  output dpStrobe_t strb,
  output logic      frameOn,
  output logic      faultClr
);
  localparam int FW = $clog2(CS_FILT_CYC + 1);
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam int BW = $clog2(BYTE_BITS);

  logic          sclkPrev;
  logic [FW-1:0] stableCnt;
  logic [LW-1:0] lowCnt;
  logic [BW-1:0] bitCnt;
  logic          gotByte;
  logic          startLow;

  logic armed, filtHit, startEv, endEv, sclkRise, sclkFall, lastBit, frameOk;

  always_comb begin
    armed    = (lowCnt == LW'(MIN_LOW_CYC));
    filtHit  = (csS != frameOn) && (stableCnt == FW'(CS_FILT_CYC - 1));
    startEv  = !frameOn && filtHit && armed;
    endEv    = frameOn && filtHit;
    sclkRise = frameOn && sclkS && !sclkPrev;
    sclkFall = frameOn && !sclkS && sclkPrev;
    lastBit  = (bitCnt == BW'(BYTE_BITS - 1));
    frameOk  = gotByte && (bitCnt == '0) && !sclkS && startLow;

    strb.load     = startEv;
    strb.sample   = sclkRise;
    strb.byteDone = sclkRise && lastBit;
    strb.shift    = sclkFall;
    strb.commit   = endEv && gotByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      stableCnt <= '0;
      lowCnt    <= '0;
      bitCnt    <= '0;
      gotByte   <= 1'b0;
      startLow  <= 1'b0;
      frameOn   <= 1'b0;
      faultClr  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      faultClr <= endEv && frameOk;

      // select must differ from the frame state for CS_FILT_CYC cycles
      if (csS == frameOn || filtHit) stableCnt <= '0;
      else                           stableCnt <= stableCnt + FW'(1);

      // re-arm timer: counts low time after a frame
      if (endEv)                            lowCnt <= '0;
      else if (!frameOn && !csS && !armed)  lowCnt <= lowCnt + LW'(1);

      if (startEv) begin
        frameOn  <= 1'b1;
        bitCnt   <= '0;
        gotByte  <= 1'b0;
        startLow <= !sclkS;
      end else if (endEv) begin
        frameOn <= 1'b0;
      end else if (sclkRise) begin
        bitCnt <= lastBit ? '0 : bitCnt + BW'(1);
        if (lastBit) gotByte <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chain_spi_dp.sv
module chain_spi_dp
  import chain_spi_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic                 sdS,
  input  logic [BYTE_BITS-1:0] faultIn,
  output logic [BYTE_BITS-1:0] cmdOut,
  output logic                 txBit
);
  logic [BYTE_BITS-1:0] rxSh, lastByte, txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      lastByte <= '0;
      txSh     <= '0;
      cmdOut   <= '0;
    end else begin
      if (strb.load) txSh <= faultIn;
      else if (strb.shift) txSh <= {txSh[BYTE_BITS-2:0], rxSh[0]};

      if (strb.sample) begin
        rxSh <= {rxSh[BYTE_BITS-2:0], sdS};
        if (strb.byteDone) lastByte <= {rxSh[BYTE_BITS-2:0], sdS};
      end

      if (strb.commit) cmdOut <= lastByte;
    end
  end

  assign txBit = txSh[BYTE_BITS-1];
endmodule

// File: rtl/chain_spi_if.sv
module chain_spi_if
  import chain_spi_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CS_FILT_CYC = 12,
  parameter int MIN_LOW_CYC = 200
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           csIn,
  input  logic           sclkIn,
  input  logic           sdIn,
  input  logic [NCH-1:0] faultIn,
  output logic [NCH-1:0] cmdOut,
  output logic           faultClr,
  output logic           sdOut,
  output logic           sdOutEn
);
  logic [2:0] syncOut;
  logic       frameOn, txBit;
  dpStrobe_t  strb;

  chain_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({csIn, sclkIn, sdIn}), .dout(syncOut)
  );

  chain_spi_ctrl #(
    .CS_FILT_CYC(CS_FILT_CYC), .MIN_LOW_CYC(MIN_LOW_CYC), .BYTE_BITS(NCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(syncOut[2]), .sclkS(syncOut[1]),
    .strb(strb), .frameOn(frameOn), .faultClr(faultClr)
  );

  chain_spi_dp #(.BYTE_BITS(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdS(syncOut[0]),
    .faultIn(faultIn), .cmdOut(cmdOut), .txBit(txBit)
  );

  assign sdOutEn = frameOn;
  assign sdOut   = frameOn & txBit;
endmodule

// File: rtl/chain_spi_chk.sv
module chain_spi_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] faultIn,
  input logic [NCH-1:0] cmdOut,
  input logic           faultClr,
  input logic           sdOut,
  input logic           sdOutEn
);
  // R7: clear request lasts one cycle
  a_r7_clr_single: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> !faultClr);

  // R7: clear request only as the frame closes
  a_r7_clr_at_end: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |-> (!sdOutEn && $past(sdOutEn)));

  // R2: first bit presented is the top fault flag seen at frame start
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOutEn) |-> (sdOut == $past(faultIn[NCH-1])));

  // R5: command register frozen inside a frame
  a_r5_cmd_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (sdOutEn && $past(sdOutEn)) |-> $stable(cmdOut));

  // R5: command register changes only at frame end
  a_r5_cmd_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdOut) |-> $fell(sdOutEn));

  // R1: no data driven while disabled
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!sdOutEn && !$past(sdOutEn)) |-> !sdOut);
endmodule

bind chain_spi_if chain_spi_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .faultIn(faultIn), .cmdOut(cmdOut),
  .faultClr(faultClr), .sdOut(sdOut), .sdOutEn(sdOutEn)
);

// File: tb/chain_spi_if_tb.sv
module chain_spi_if_tb;
  localparam int HP = 8;

  typedef struct packed {
    logic [7:0]  fault;
    logic [7:0]  fmid;
    logic [4:0]  nbits;
    logic [15:0] data;
    logic        endHigh;
    logic        startHigh;
    logic        expClr;
    logic [7:0]  expCmd;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'hA5, 8'hA5, 5'd8,  16'h3C00, 1'b0, 1'b0, 1'b1, 8'h3C},
    '{8'h0F, 8'hF0, 5'd16, 16'h81C3, 1'b0, 1'b0, 1'b1, 8'hC3},
    '{8'hFF, 8'hFF, 5'd5,  16'hA800, 1'b0, 1'b0, 1'b0, 8'hC3},
    '{8'h12, 8'h12, 5'd8,  16'h5500, 1'b1, 1'b0, 1'b0, 8'h55},
    '{8'h00, 8'h00, 5'd8,  16'hAA00, 1'b0, 1'b1, 1'b0, 8'hAA},
    '{8'h80, 8'h80, 5'd12, 16'hE790, 1'b0, 1'b0, 1'b0, 8'hE7},
    '{8'h01, 8'h01, 5'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 8'hE7}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic csIn = 1'b0, sclkIn = 1'b0, sdIn = 1'b0;
  logic [7:0] faultIn = 8'h00;
  logic [7:0] cmdOut;
  logic faultClr, sdOut, sdOutEn;

  int checks = 0, errors = 0, cyc = 0;
  int clrCnt = 0, oeRise = 0;
  logic [7:0] cmdAtClr = 8'h00;
  logic oePrev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_spi_if u_dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .faultIn(faultIn), .cmdOut(cmdOut), .faultClr(faultClr),
    .sdOut(sdOut), .sdOutEn(sdOutEn)
  );

  always @(negedge clk) begin
    if (faultClr) begin
      clrCnt++;
      cmdAtClr = cmdOut;
    end
    if (sdOutEn && !oePrev) oeRise++;
    oePrev = sdOutEn;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic runFrame(input vec_t v);
    int c0;
    logic [15:0] got;
    logic expBit;
    c0 = clrCnt;
    got = '0;
    faultIn = v.fault;
    if (v.startHigh) sclkIn = 1'b1;
    wc(4);
    csIn = 1'b1;
    wc(24);
    chk(sdOutEn == 1'b1, "R1 enable at start", sdOutEn, 1);
    faultIn = v.fmid;  // late fault change must not reach this frame (R2)
    if (v.startHigh) begin sclkIn = 1'b0; wc(HP); end
    for (int i = 0; i < int'(v.nbits); i++) begin
      got[i] = sdOut;
      sdIn = v.data[15-i];
      wc(HP);
      sclkIn = 1'b1;
      wc(HP);
      if (!v.startHigh) chk(sdOut == got[i], "R4 steady while clock high", sdOut, got[i]);
      if (!(v.endHigh && i == int'(v.nbits) - 1)) begin
        sclkIn = 1'b0;
        wc(HP);
      end
    end
    if (!v.startHigh) begin
      for (int i = 0; i < int'(v.nbits); i++) begin
        expBit = (i < 8) ? v.fault[7-i] : v.data[15-(i-8)];
        chk(got[i] == expBit, (i < 8) ? "R2 fault byte" : "R3 chained bit", got[i], expBit);
      end
    end
    csIn = 1'b0;
    wc(30);
    sclkIn = 1'b0;
    sdIn = 1'b0;
    chk(!sdOutEn && !sdOut, "R1 released", {sdOutEn, sdOut}, 0);
    chk(cmdOut == v.expCmd, "R5 R6 command", cmdOut, v.expCmd);
    chk((clrCnt - c0) == int'(v.expClr), "R7 clear count", clrCnt - c0, v.expClr);
    if (v.expClr) chk(cmdAtClr == v.expCmd, "R5 R7 same cycle", cmdAtClr, v.expCmd);
  endtask

  initial begin
    int r0;
    wc(5);
    rstN = 1'b1;
    wc(2);
    chk(cmdOut == 8'h00, "R10 command reset", cmdOut, 0);
    chk(!faultClr && !sdOutEn && !sdOut, "R10 outputs reset", {faultClr, sdOutEn, sdOut}, 0);
    wc(250);

    for (int k = 0; k < 7; k++) begin
      runFrame(VEC[k]);
      wc(250);
    end

    // R8: short select pulse
    r0 = oeRise;
    csIn = 1'b1; wc(6); csIn = 1'b0; wc(40);
    chk(oeRise == r0, "R8 glitch rejected", oeRise - r0, 0);
    chk(cmdOut == 8'hE7, "R8 command untouched", cmdOut, 8'hE7);

    // R9: re-select too soon after a frame
    runFrame('{8'h00, 8'h00, 5'd8, 16'h0F00, 1'b0, 1'b0, 1'b1, 8'h0F});
    r0 = oeRise;
    csIn = 1'b1;
    wc(24);
    for (int i = 0; i < 8; i++) begin
      sdIn = i[0];
      wc(HP); sclkIn = 1'b1; wc(HP); sclkIn = 1'b0; wc(HP);
    end
    csIn = 1'b0;
    wc(30);
    chk(oeRise == r0, "R9 early frame ignored", oeRise - r0, 0);
    chk(cmdOut == 8'h0F, "R9 command untouched", cmdOut, 8'h0F);
    wc(250);
    runFrame('{8'h3C, 8'h3C, 5'd8, 16'h6600, 1'b0, 1'b0, 1'b1, 8'h66});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule